// File: doc/BRIEF.md
# CDS Clamp Extension Timer

This block generates the clamp (reset) strobe for the correlated-double-sampling stage of a pixel readout channel. The strobe follows the integrator reset. It goes high when the integrator reset goes high. After the integrator reset falls, the strobe stays high for a programmable number of extra time steps. Lengthening this clamp shortens the interval between clamp and sample-hold, which filters more low-frequency noise.

All timing runs in the master-clock domain. A twisted-ring divider produces one step strobe every 18 master cycles. A Gray-coded step counter runs only inside the window opened by the integrator-reset falling edge. The counter's next value is compared against the Gray form of a 4-bit code captured on that same edge, and the match ends the clamp. A disable input turns the clamp off for characterisation runs without CDS.

Top module: `cdsClampTimer`

## Requirements
- R1: After reset, `cdsRst` and `busy` are low.
- R2: `risePulse` is high exactly while `intRst` is 1 and was 0 at the previous clock edge. `fallPulse` is high exactly while `intRst` is 0 and was 1 at the previous clock edge.
- R3: When `cdsOff` is low, `cdsRst` goes high at the first clock edge that samples `risePulse`.
- R4: `delayCode` is read as an unsigned count N of 18-cycle steps. When N is nonzero, `cdsRst` falls exactly 18·N clock edges after the edge that samples `fallPulse`, and `busy` falls at the same edge. The internal step counter advances in Gray code, one bit at a time.
- R5: With code 0, `cdsRst` falls at the same edge that samples `fallPulse`, and `busy` stays low.
- R6: For a nonzero code, `busy` rises at the edge that samples `fallPulse` and stays high until the clamp ends.
- R7: The code is captured at the falling-edge pulse. Changing `delayCode` while `busy` is high does not change the current clamp length.
- R8: A rising pulse while `busy` is high clears `busy` at that edge and keeps `cdsRst` high. The next falling pulse starts a full new count.
- R9: While `cdsOff` is sampled high, `cdsRst` and `busy` are low from the next edge on, and the edge pulses keep working. After `cdsOff` returns low, the clamp re-arms only on a new rising pulse.
- R10: Code 15 gives the longest extension, which is 270 master-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intRst | input | 1 | Integrator reset level, synchronous to clk |
| delayCode | input | 4 | Extension in steps, unsigned binary |
| cdsOff | input | 1 | Test mode: hold the clamp inactive |
| cdsRst | output | 1 | CDS clamp strobe |
| busy | output | 1 | Extension count in progress |
| risePulse | output | 1 | One-cycle pulse on an intRst rising edge |
| fallPulse | output | 1 | One-cycle pulse on an intRst falling edge |

## Verification
Directed frames check the points where the length rule breaks: code 0 (clamp ends at the edge itself), code 1 (one step), and code 15 (the 270-cycle maximum, measured by a cycle count). Further directed frames change the code while counting, which separates a design that latches the code from one that compares against the live input. They also raise the integrator reset again mid-count, which shows whether the count restarts cleanly. Random frames use high and low times both shorter and longer than the programmed extension, with random codes and occasional disable periods. A per-cycle expected model tells apart off-by-one step lengths, a stale divider phase and disable-mode leakage.

// File: rtl/cdsTimerPkg.sv
`timescale 1ns/1ps
package cdsTimerPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;   // zero the divider and step counter
    logic run;     // advance the divider / counter
    logic load;    // capture the delay code
  } ctlStrobeT;

endpackage

// File: rtl/cdsTimerDatapath.sv
`timescale 1ns/1ps
module cdsTimerDatapath
  import cdsTimerPkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int DIV_STAGES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intRst,
  input  logic [CODE_W-1:0] code,
  input  ctlStrobeT         ctl,
  output logic              risePulse,
  output logic              fallPulse,
  output logic              codeZero,
  output logic              hitStep
);

  localparam logic [DIV_STAGES-1:0] LastPhase = {1'b1, {(DIV_STAGES-1){1'b0}}};

  logic                  intRstQ;
  logic [DIV_STAGES-1:0] ring;
  logic                  stepTick;
  logic [CODE_W-1:0]     codeQ;
  logic [CODE_W-1:0]     grayCnt;
  logic [CODE_W-1:0]     grayNext;
  logic [CODE_W-1:0]     grayTarget;

  function automatic logic [CODE_W-1:0] toGray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] fromGray(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Edge detection on the integrator reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intRstQ <= 1'b0;
    else       intRstQ <= intRst;
  end

  assign risePulse = intRst & ~intRstQ;
  assign fallPulse = ~intRst & intRstQ;

  // Twisted-ring step divider: 2*DIV_STAGES phases per step
  for (genvar s = 0; s < DIV_STAGES; s++) begin : gStage
    logic feed;
    if (s == 0) begin : gHead
      assign feed = ~ring[DIV_STAGES-1];
    end else begin : gBody
      assign feed = ring[s-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          ring[s] <= 1'b0;
      else if (ctl.clear) ring[s] <= 1'b0;
      else if (ctl.run)   ring[s] <= feed;
    end
  end

  assign stepTick = (ring == LastPhase);

  // Code capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         codeQ <= '0;
    else if (ctl.load) codeQ <= code;
  end

  // Gray step counter
  assign grayNext   = toGray(fromGray(grayCnt) + 1'b1);
  assign grayTarget = toGray(codeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     grayCnt <= '0;
    else if (ctl.clear)            grayCnt <= '0;
    else if (ctl.run && stepTick)  grayCnt <= grayNext;
  end

  assign hitStep  = stepTick && (grayNext == grayTarget);
  assign codeZero = (code == '0);

  AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (grayCnt != $past(grayCnt)) && !$past(ctl.clear) |-> $countones(grayCnt ^ $past(grayCnt)) == 1); // R4
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    risePulse |=> !risePulse); // R2
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |=> !fallPulse); // R2

endmodule

// File: rtl/cdsTimerControl.sv
`timescale 1ns/1ps
module cdsTimerControl
  import cdsTimerPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cdsOff,
  input  logic      risePulse,
  input  logic      fallPulse,
  input  logic      codeZero,
  input  logic      hitStep,
  output ctlStrobeT ctl,
  output logic      cdsRst,
  output logic      busy
);

  logic clampQ;
  logic busyQ;
  logic matchPulse;

  assign matchPulse = (fallPulse && codeZero) || (busyQ && hitStep);

  always_comb begin
    ctl.load  = fallPulse;
    ctl.clear = risePulse | fallPulse | cdsOff;
    ctl.run   = busyQ;
  end

  // Set/reset clamp latch: rising pulse sets, match clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           clampQ <= 1'b0;
    else if (cdsOff)     clampQ <= 1'b0;
    else if (risePulse)  clampQ <= 1'b1;
    else if (matchPulse) clampQ <= 1'b0;
  end

  // Counting window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           busyQ <= 1'b0;
    else if (cdsOff)     busyQ <= 1'b0;
    else if (risePulse)  busyQ <= 1'b0;
    else if (fallPulse)  busyQ <= ~codeZero;
    else if (matchPulse) busyQ <= 1'b0;
  end

  assign cdsRst = clampQ;
  assign busy   = busyQ;

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    risePulse && !cdsOff |=> cdsRst && !busy); // R3
  AST_ZERO_CODE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse && codeZero |=> !cdsRst && !busy); // R5
  AST_FALL_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse && !codeZero && !cdsOff |=> busy); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cdsOff |=> !cdsRst && !busy); // R9
  AST_BUSY_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fallPulse)); // R6

endmodule

// File: rtl/cdsClampTimer.sv
`timescale 1ns/1ps
module cdsClampTimer
  import cdsTimerPkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int DIV_STAGES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intRst,
  input  logic [CODE_W-1:0] delayCode,
  input  logic              cdsOff,
  output logic              cdsRst,
  output logic              busy,
  output logic              risePulse,
  output logic              fallPulse
);

  ctlStrobeT ctl;
  logic      codeZero;
  logic      hitStep;

  cdsTimerDatapath #(
    .CODE_W    (CODE_W),
    .DIV_STAGES(DIV_STAGES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .intRst   (intRst),
    .code     (delayCode),
    .ctl      (ctl),
    .risePulse(risePulse),
    .fallPulse(fallPulse),
    .codeZero (codeZero),
    .hitStep  (hitStep)
  );

  cdsTimerControl i_control (
    .clk      (clk),
    .rstN     (rstN),
    .cdsOff   (cdsOff),
    .risePulse(risePulse),
    .fallPulse(fallPulse),
    .codeZero (codeZero),
    .hitStep  (hitStep),
    .ctl      (ctl),
    .cdsRst   (cdsRst),
    .busy     (busy)
  );

endmodule

// File: tb/test_cdsClampTimer.sv
`timescale 1ns/1ps
module test_cdsClampTimer;

  localparam int STEP = 18;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intRst = 1'b0;
  logic [3:0] delayCode = 4'd0;
  logic       cdsOff = 1'b0;
  logic       cdsRst, busy, risePulse, fallPulse;

  always #2 clk = ~clk;

  cdsClampTimer i_cdsClampTimer (
    .clk(clk), .rstN(rstN), .intRst(intRst), .delayCode(delayCode),
    .cdsOff(cdsOff), .cdsRst(cdsRst), .busy(busy),
    .risePulse(risePulse), .fallPulse(fallPulse)
  );

  int    nCmp = 0;
  int    nBad = 0;
  string tag = "R1";
  bit    checking = 1'b0;
  bit    finished = 1'b0;

  // Expected-value model, built from the requirements
  bit prevIn = 1'b0;
  bit mRst = 1'b0;
  bit mBusy = 1'b0;
  int remain = 0;

  function automatic int stepsFor(input logic [3:0] c);
    return STEP * int'(c);
  endfunction

  always @(posedge clk) begin
    bit rise, fall;
    rise = intRst && !prevIn;
    fall = !intRst && prevIn;
    if (!rstN) begin
      mRst = 0; mBusy = 0; remain = 0; prevIn = 0;
    end else begin
      if (cdsOff) begin
        mRst = 0; mBusy = 0;
      end else if (rise) begin
        mRst = 1; mBusy = 0;
      end else if (fall) begin
        if (delayCode == 4'd0) mRst = 0;
        else begin mBusy = 1; remain = stepsFor(delayCode); end
      end else if (mBusy) begin
        remain--;
        if (remain == 0) begin mBusy = 0; mRst = 0; end
      end
      prevIn = intRst;
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (checking) begin
      cmp("cdsRst", cdsRst, mRst);
      cmp("busy", busy, mBusy);
      cmp("R2 risePulse", risePulse, intRst && !prevIn);
      cmp("R2 fallPulse", fallPulse, !intRst && prevIn);
    end
  end

  task automatic frame(input int hi, input int lo, input logic [3:0] c);
    @(negedge clk); intRst = 1'b1; delayCode = c;
    repeat (hi) @(negedge clk);
    intRst = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4117));
    repeat (3) @(posedge clk);
    checking = 1'b1;
    tag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R5"; frame(4, 10, 4'd0);
    tag = "R3"; frame(1, 30, 4'd1);
    tag = "R6"; frame(6, 80, 4'd3);

    // R10: longest extension measured directly
    tag = "R10";
    @(negedge clk); intRst = 1'b1; delayCode = 4'd15;
    repeat (5) @(negedge clk);
    intRst = 1'b0;
    begin
      int cnt = 0;
      @(negedge clk);
      while (cdsRst && cnt < 400) begin cnt++; @(negedge clk); end
      nCmp++;
      if (cnt != 270) begin
        nBad++;
        $display("FAIL R10 clamp length: actual %0d expected %0d", cnt, 270);
      end
    end
    repeat (5) @(negedge clk);

    // R7: code changed mid-count
    tag = "R7";
    @(negedge clk); intRst = 1'b1; delayCode = 4'd3;
    repeat (3) @(negedge clk);
    intRst = 1'b0;
    repeat (10) @(negedge clk);
    delayCode = 4'd9;
    repeat (60) @(negedge clk);
    delayCode = 4'd0;
    repeat (20) @(negedge clk);

    // R8: rise during counting restarts
    tag = "R8";
    frame(3, 50, 4'd10);
    frame(5, 60, 4'd2);

    // R9: disable mode
    tag = "R9";
    @(negedge clk); cdsOff = 1'b1;
    frame(4, 40, 4'd1);
    @(negedge clk); intRst = 1'b1;
    repeat (3) @(negedge clk);
    cdsOff = 1'b0;
    repeat (4) @(negedge clk);
    intRst = 1'b0;
    repeat (10) @(negedge clk);
    frame(2, 25, 4'd1);

    // R4: random frames
    tag = "R4";
    for (int f = 0; f < 60; f++) begin
      int hi, lo;
      logic [3:0] c;
      hi = 1 + int'($urandom % 12);
      lo = int'($urandom % 300);
      c  = 4'($urandom);
      cdsOff = (($urandom % 8) == 0);
      @(negedge clk); intRst = 1'b1; delayCode = c;
      repeat (hi) @(negedge clk);
      intRst = 1'b0;
      repeat (lo / 2) @(negedge clk);
      delayCode = 4'($urandom);
      repeat (lo - lo / 2) @(negedge clk);
      cdsOff = 1'b0;
    end
    repeat (300) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule